// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the serial boundary-scan register that sits between a device's core logic and its I/O pads. Every pad owns a group of three scan cells: one for the output enable, one for the output value and one for the input value. The groups are linked into a single serial chain. The test-access controller steers the chain with four level signals: capture, shift, update and test mode. With these it loads a snapshot of the pin and core state into the chain, moves the snapshot out through the serial output while fresh test data comes in from the serial input, and then commits that data to per-cell holding registers.

When test mode is off, the pads see the core's enable and output signals unchanged. When test mode is on, the pad enable and pad output come from the holding registers. The pins can then be forced to any pattern that was shifted in, while the core plays no part. The holding registers change only on an update, so shifting never disturbs the pins.

All state changes on the rising edge of the test clock. A single active-low asynchronous reset clears every shift stage and every holding register.

Top module: `bsr_chain`

## Requirements
- R1: While reset is asserted and after it is released, every shift stage and holding register is 0. The serial output reads 0, and in test mode every pad enable and pad output reads 0.
- R2: The chain is exactly 3×PADS bits long. A bit presented on the serial input during the first of a run of shift cycles reaches the serial output after exactly 3×PADS shift edges.
- R3: On a capture edge, the chain loads in parallel. Chain bit 3p+2 takes the core enable of pad p, bit 3p+1 takes the core output of pad p, and bit 3p takes the pad input of pad p. Bit 0 drives the serial output. Reading from the serial-input end, each pad's cells therefore run enable, output, input.
- R4: On a shift edge, every chain bit moves one place toward bit 0, and bit 3×PADS−1 takes the serial input.
- R5: On an update edge, every holding register copies its shift stage. In test mode, pad enable p equals holding bit 3p+2 and pad output p equals holding bit 3p+1.
- R6: The holding registers, and therefore the pad enable and pad output in test mode, keep their values on every edge that is not a selected update. This includes shift and capture edges.
- R7: With test mode off, pad enable and pad output equal the core enable and core output in the same cycle, whatever the chain holds.
- R8: When more than one strobe is high at one edge, capture wins over shift and shift wins over update. The losing strobes have no effect on the chain or on the holding registers.
- R9: On an edge with neither capture nor shift high, the chain keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of chain and holding registers |
| tdi | input | 1 | Serial scan input, entering at the highest chain bit |
| captureEn | input | 1 | Parallel-load strobe |
| shiftEn | input | 1 | Serial-shift strobe |
| updateEn | input | 1 | Commit chain contents to holding registers |
| testMode | input | 1 | 1 = pads driven from holding registers, 0 = core pass-through |
| coreOe | input | PADS | Output enables from the core, one per pad |
| coreOut | input | PADS | Output values from the core, one per pad |
| padIn | input | PADS | Values received at the pads |
| padOe | output | PADS | Output enables delivered to the pads |
| padOut | output | PADS | Output values delivered to the pads |
| scanOut | output | 1 | Serial scan output, chain bit 0 |

## Verification
The bench first measures the chain length with a single marker bit. A chain one cell too short or too long shows up as a wrong arrival count. It then captures distinct per-pad patterns and reads them out serially: a swapped enable and output cell, or a reversed pad order, gives a wrong bit at a known position. It also fires capture, shift and update together to expose a wrong priority, and shifts while in test mode. A holding register that follows the shift stage would make the pins flicker during that shift. A behavioural queue model is compared with every output on every cycle through a long stretch of random strobe traffic.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int CELLS_PER_PAD = 3;

  // position of each cell inside its pad group (0 = nearest the serial output)
  typedef enum logic [1:0] {
    CELL_IN  = 2'd0,
    CELL_OUT = 2'd1,
    CELL_OE  = 2'd2
  } cellKind_e;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic testSel;
  } bsrStrobes_t;
endpackage

// File: rtl/bsr_control.sv
module bsr_control
  import bsr_pkg::*;
(
  input  logic        captureEn,
  input  logic        shiftEn,
  input  logic        updateEn,
  input  logic        testMode,
  output bsrStrobes_t strobes
);
  // capture outranks shift, shift outranks update
  always_comb begin
    strobes.capture = captureEn;
    strobes.shift   = shiftEn & ~captureEn;
    strobes.update  = updateEn & ~shiftEn & ~captureEn;
    strobes.testSel = testMode;
  end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  bsrStrobes_t strobes,
  input  logic        parIn,
  input  logic        serIn,
  output logic        shiftQ,
  output logic        holdQ
);
  logic shiftNext;

  // first multiplexer: parallel load, serial move or keep
  always_comb begin
    if (strobes.capture)    shiftNext = parIn;
    else if (strobes.shift) shiftNext = serIn;
    else                    shiftNext = shiftQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= 1'b0;
    else       shiftQ <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdQ <= 1'b0;
    else if (strobes.update) holdQ <= shiftQ;
  end
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int PADS = 8,
  localparam int CHAIN_LEN = CELLS_PER_PAD * PADS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bsrStrobes_t          strobes,
  input  logic                 tdi,
  input  logic [PADS-1:0]      coreOe,
  input  logic [PADS-1:0]      coreOut,
  input  logic [PADS-1:0]      padIn,
  output logic [PADS-1:0]      padOe,
  output logic [PADS-1:0]      padOut,
  output logic                 scanOut,
  output logic [CHAIN_LEN-1:0] shiftVec,
  output logic [CHAIN_LEN-1:0] holdVec
);
  logic [CHAIN_LEN-1:0] parVec;
  logic [CHAIN_LEN-1:0] serVec;

  for (genvar p = 0; p < PADS; p++) begin : g_pad
    for (genvar k = 0; k < CELLS_PER_PAD; k++) begin : g_cell
      localparam int IDX = p * CELLS_PER_PAD + k;

      if (k == int'(CELL_OE)) begin : g_oe
        assign parVec[IDX] = coreOe[p];
      end else if (k == int'(CELL_OUT)) begin : g_out
        assign parVec[IDX] = coreOut[p];
      end else begin : g_in
        assign parVec[IDX] = padIn[p];
      end

      if (IDX == CHAIN_LEN - 1) begin : g_head
        assign serVec[IDX] = tdi;
      end else begin : g_link
        assign serVec[IDX] = shiftVec[IDX+1];
      end

      bsr_cell u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .strobes(strobes),
        .parIn  (parVec[IDX]),
        .serIn  (serVec[IDX]),
        .shiftQ (shiftVec[IDX]),
        .holdQ  (holdVec[IDX])
      );
    end

    // second multiplexer: functional versus test data toward the pad
    assign padOe[p]  = strobes.testSel ? holdVec[p*CELLS_PER_PAD + int'(CELL_OE)]  : coreOe[p];
    assign padOut[p] = strobes.testSel ? holdVec[p*CELLS_PER_PAD + int'(CELL_OUT)] : coreOut[p];
  end

  assign scanOut = shiftVec[0];
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int PADS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tdi,
  input  logic            captureEn,
  input  logic            shiftEn,
  input  logic            updateEn,
  input  logic            testMode,
  input  logic [PADS-1:0] coreOe,
  input  logic [PADS-1:0] coreOut,
  input  logic [PADS-1:0] padIn,
  output logic [PADS-1:0] padOe,
  output logic [PADS-1:0] padOut,
  output logic            scanOut
);
  localparam int CHAIN_LEN = CELLS_PER_PAD * PADS;

  bsrStrobes_t          strobes;
  logic [CHAIN_LEN-1:0] shiftVec;
  logic [CHAIN_LEN-1:0] holdVec;

  bsr_control u_control (
    .captureEn(captureEn),
    .shiftEn  (shiftEn),
    .updateEn (updateEn),
    .testMode (testMode),
    .strobes  (strobes)
  );

  bsr_datapath #(.PADS(PADS)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .tdi     (tdi),
    .coreOe  (coreOe),
    .coreOut (coreOut),
    .padIn   (padIn),
    .padOe   (padOe),
    .padOut  (padOut),
    .scanOut (scanOut),
    .shiftVec(shiftVec),
    .holdVec (holdVec)
  );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int PADS = 8,
  localparam int CHAIN_LEN = 3 * PADS
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tdi,
  input logic                 captureEn,
  input logic                 shiftEn,
  input logic                 updateEn,
  input logic                 testMode,
  input logic [PADS-1:0]      coreOe,
  input logic [PADS-1:0]      coreOut,
  input logic [PADS-1:0]      padIn,
  input logic [PADS-1:0]      padOe,
  input logic [PADS-1:0]      padOut,
  input logic                 scanOut,
  input logic [CHAIN_LEN-1:0] shiftVec,
  input logic [CHAIN_LEN-1:0] holdVec
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (shiftVec == '0 && holdVec == '0));

  assert_capture_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> (scanOut == $past(padIn[0]) && shiftVec[1] == $past(coreOut[0])
                   && shiftVec[2] == $past(coreOe[0])
                   && shiftVec[CHAIN_LEN-1] == $past(coreOe[PADS-1])));

  assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !captureEn) |=> (shiftVec[CHAIN_LEN-1] == $past(tdi)
                                 && scanOut == $past(shiftVec[1])));

  assert_update_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && !shiftEn && !captureEn) |=> holdVec == $past(shiftVec));

  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(updateEn && !shiftEn && !captureEn) |=> $stable(holdVec));

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (padOe == coreOe && padOut == coreOut));

  assert_test_pins_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !updateEn && $past(testMode) && !$past(updateEn))
      |-> ($stable(padOe) && $stable(padOut)));

  assert_idle_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!captureEn && !shiftEn) |=> $stable(shiftVec));
endmodule

bind bsr_chain bsr_chain_chk #(.PADS(PADS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tdi      (tdi),
  .captureEn(captureEn),
  .shiftEn  (shiftEn),
  .updateEn (updateEn),
  .testMode (testMode),
  .coreOe   (coreOe),
  .coreOut  (coreOut),
  .padIn    (padIn),
  .padOe    (padOe),
  .padOut   (padOut),
  .scanOut  (scanOut),
  .shiftVec (shiftVec),
  .holdVec  (holdVec)
);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;
  localparam int PADS = 5;
  localparam int LEN  = 3 * PADS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rstN = 1'b0;
  logic            tdi = 1'b0, captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0;
  logic            testMode = 1'b0;
  logic [PADS-1:0] coreOe = '0, coreOut = '0, padIn = '0;
  logic [PADS-1:0] padOe, padOut;
  logic            scanOut;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  bsr_chain #(.PADS(PADS)) i_bsr_chain (
    .clk(clk), .rstN(rstN), .tdi(tdi), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .testMode(testMode), .coreOe(coreOe), .coreOut(coreOut),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .scanOut(scanOut)
  );

  // behavioural reference: queue front is the bit nearest the serial output
  logic mq[$];
  logic mh[LEN];

  function automatic logic capBit(int i);
    int pad = i / 3;
    case (i % 3)
      2:       return coreOe[pad];
      1:       return coreOut[pad];
      default: return padIn[pad];
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mq.delete();
      for (int i = 0; i < LEN; i++) begin mq.push_back(1'b0); mh[i] = 1'b0; end
    end else if (captureEn) begin
      for (int i = 0; i < LEN; i++) mq[i] = capBit(i);
    end else if (shiftEn) begin
      void'(mq.pop_front());
      mq.push_back(tdi);
    end else if (updateEn) begin
      for (int i = 0; i < LEN; i++) mh[i] = mq[i];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compareModel();
    logic [PADS-1:0] eOe, eOut;
    for (int p = 0; p < PADS; p++) begin
      eOe[p]  = testMode ? mh[3*p+2] : coreOe[p];
      eOut[p] = testMode ? mh[3*p+1] : coreOut[p];
    end
    chk("R4 model scanOut", 32'(scanOut), 32'(mq[0]));
    chk("R5/R7 model padOe", 32'(padOe), 32'(eOe));
    chk("R5/R7 model padOut", 32'(padOut), 32'(eOut));
  endtask

  // compare at the falling edge, drive, then let one rising edge pass
  task automatic tick(logic cap, logic sh, logic up, logic d);
    @(negedge clk);
    compareModel();
    captureEn = cap; shiftEn = sh; updateEn = up; tdi = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [PADS-1:0] keepOe, keepOut;
    logic pat[LEN];
    int cnt;

    testMode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset contents
    chk("R1 scanOut", 32'(scanOut), 0);
    chk("R1 padOe", 32'(padOe), 0);
    chk("R1 padOut", 32'(padOut), 0);
    @(negedge clk) rstN = 1'b1;
    tick(0, 0, 0, 0);
    chk("R1 padOe after release", 32'(padOe), 0);

    // R7: pass-through in normal mode
    testMode = 1'b0; coreOe = 5'b10110; coreOut = 5'b01101;
    #1;
    chk("R7 padOe", 32'(padOe), 32'(5'b10110));
    chk("R7 padOut", 32'(padOut), 32'(5'b01101));

    // R2: marker bit length measurement
    tick(0, 1, 0, 1);
    cnt = 1;
    while (scanOut !== 1'b1 && cnt < 2 * LEN) begin tick(0, 1, 0, 0); cnt++; end
    chk("R2 chain length", 32'(cnt), 32'(LEN));

    // R3: capture ordering read out serially
    coreOe = 5'b11001; coreOut = 5'b01010; padIn = 5'b10011;
    tick(1, 0, 0, 0);
    for (int k = 0; k < LEN; k++) begin
      chk($sformatf("R3 bit %0d", k), 32'(scanOut), 32'(capBit(k)));
      tick(0, 1, 0, 0);
    end

    // R5: load pattern, update, drive pins in test mode
    for (int k = 0; k < LEN; k++) pat[k] = ((k * 7 + 3) % 5) < 2;
    for (int k = 0; k < LEN; k++) tick(0, 1, 0, pat[k]);
    tick(0, 0, 1, 0);
    testMode = 1'b1;
    tick(0, 0, 0, 0);
    for (int p = 0; p < PADS; p++) begin
      chk($sformatf("R5 padOe[%0d]", p), 32'(padOe[p]), 32'(pat[3*p+2]));
      chk($sformatf("R5 padOut[%0d]", p), 32'(padOut[p]), 32'(pat[3*p+1]));
    end

    // R6: shifting and capturing leave the pins alone
    keepOe = padOe; keepOut = padOut;
    for (int k = 0; k < LEN; k++) begin
      tick(0, 1, 0, ~pat[k]);
      chk("R6 padOe during shift", 32'(padOe), 32'(keepOe));
    end
    tick(1, 0, 0, 0);
    chk("R6 padOut after capture", 32'(padOut), 32'(keepOut));

    // R8: capture beats shift and update
    padIn = 5'b00001; coreOut = 5'b00000;
    tick(1, 1, 1, 0);
    chk("R8 capture wins", 32'(scanOut), 1);
    chk("R8 no update", 32'(padOe), 32'(keepOe));
    // shift beats update
    tick(0, 1, 1, 1);
    chk("R8 shift wins scan", 32'(scanOut), 0);
    chk("R8 shift wins pins", 32'(padOut), 32'(keepOut));

    // R9: idle keeps chain
    cnt = int'(scanOut);
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 0);
    chk("R9 idle hold", 32'(scanOut), 32'(cnt));

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 15);
      if (n % 97 == 0) testMode = ~testMode;
      coreOe = PADS'($urandom); coreOut = PADS'($urandom); padIn = PADS'($urandom);
      tick(r == 0, r > 1 && r < 11, r >= 11 && r < 14 || r == 1, 1'($urandom));
    end
    tick(0, 0, 0, 0);
    @(negedge clk);
    compareModel();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule